// File: doc/BRIEF.md
# Keyed Configuration Port Unlock

This block gives a host a two-port, indexed path into the configuration space of an I/O controller. One byte port takes a register index; the neighbouring byte port reads or writes the register that the index selects. The space stays closed after reset. It opens only when a fixed four-byte key is written to the index port, one byte after another. It closes again when an exit command is written through the index/data pair.

Inside the open space, a small set of global registers sits below index 0x30. These hold the logical device number, a 16-bit chip identifier and a revision nibble. The device number banks everything at 0x30 and above. For each of the first `NUM_LDN` devices the block keeps an activate bit and a 16-bit I/O base address, and drives them out as plain pins. Every other banked index is forwarded on a register-file bus to the attached logical device. That bus carries the device number, the index, the write data, a write strobe, a read strobe and a read-data return.

The host request channel is valid/ready. A request moves on a cycle where both `host_valid` and `host_ready` are high, and the host must hold a request steady while `host_ready` is low. Every accepted read is answered exactly one cycle later by a single-cycle `rsp_valid` pulse. The response channel has no back-pressure. Instead, `host_ready` stays low during the response cycle, so at most one read is ever in flight.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the space is closed (`cfg_open` low). It opens when four consecutive index-port writes carry 0x87, 0x01, 0x55, 0x55. A sequence with any other value in any one position leaves it closed.
- R2: An index-port write that does not match the expected key byte restarts key matching. A mismatching byte of 0x87 counts as the first byte of a new attempt, so 0x87 0x87 0x01 0x55 0x55 opens the space, while 0x87 0x33 0x01 0x55 0x55 does not.
- R3: While closed, data-port writes change no register and raise no `dev_we`. Reads of either port return 0xFF, so a host probing the identifier sees 0xFFFF.
- R4: While open, an index-port write selects the register index, and an index-port read returns the selected index.
- R5: While open, a data-port write to index 0x02 with bit 1 of the data set closes the space. The same write with bit 1 clear has no effect. Index 0x02 reads 0x00.
- R6: Index 0x07 holds the logical device number. It is readable and writable, drives `dev_num`, and resets to 0, including a reset taken while open.
- R7: Index 0x20 returns the identifier high byte and 0x21 the low byte (default 0xA5C3). Index 0x22 returns the revision in bits 3:0 (default 3), with bits 7:4 zero.
- R8: For device numbers below `NUM_LDN`, index 0x30 holds the activate bit in data bit 0 (other bits read 0). Index 0x60 holds the base address high byte and 0x61 the low byte. Each device keeps its own copy, visible on `dev_active[n]` and `dev_base[16n+15:16n]`.
- R9: Every other index at or above 0x30 is forwarded to the device bus, as are 0x30/0x60/0x61 when the device number is `NUM_LDN` or more. An accepted data write pulses `dev_we` for one cycle with `dev_num`, `dev_index` and `dev_wdata` valid. An accepted data read pulses `dev_re`, and the value on `dev_rdata` in that cycle is returned to the host.
- R10: An accepted read is answered by `rsp_valid` in the next cycle only, with `host_ready` low in that cycle. Writes to addresses other than the two ports are ignored, and reads of them return 0xFF.
- R11: Unused global indices below 0x30 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 8 | Read response byte |
| cfg_open | output | 1 | Configuration space is open |
| dev_num | output | 8 | Selected logical device number |
| dev_index | output | 8 | Selected register index |
| dev_wdata | output | 8 | Write data toward devices |
| dev_we | output | 1 | Device register write strobe |
| dev_re | output | 1 | Device register read strobe |
| dev_rdata | input | 8 | Read data from the addressed device |
| dev_active | output | NUM_LDN | Activate bit of each banked device |
| dev_base | output | 16*NUM_LDN | I/O base of each banked device, device n at bits 16n+15:16n |

## Verification
The hardest case to reach is a key attempt that breaks partway through on a byte that is itself a legal key byte. For example, 0x87 arriving where 0x01 is expected must restart matching rather than clear it. To reach it, the stimulus sweeps all 256 byte values through each of the second, third and fourth key positions. The bench expects the space to open exactly when the swept value equals the key byte for that position, and it also replays hand-picked interleaved restart sequences. The per-device banks are then filled with distinct arithmetic patterns for every device and read back both through the data port and at the output pins, which exposes any cross-talk between banks.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int KEY_LEN = 4;
  // Key bytes in the order they must arrive; element 0 first.
  localparam logic [KEY_LEN-1:0][7:0] ENTRY_KEY = {8'h55, 8'h55, 8'h01, 8'h87};

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BANK_LO = 8'h30;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  localparam int         EXIT_BIT    = 1;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;

  typedef enum logic [1:0] {
    PORT_NONE  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2
  } port_sel_e;
endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_byte,
  input  logic       lock_req,
  output logic       open
);
  localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic              open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      open_q <= 1'b0;
    end else if (lock_req) begin
      step_q <= '0;
      open_q <= 1'b0;
    end else if (key_we && !open_q) begin
      if (key_byte == ENTRY_KEY[step_q]) begin
        if (step_q == LAST_STEP) begin
          open_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end else if (key_byte == ENTRY_KEY[0]) begin
        step_q <= STEP_W'(1);
      end else begin
        step_q <= '0;
      end
    end
  end

  assign open = open_q;
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic       dat_we,
  input  logic [7:0] wdata,
  output logic [7:0] cur_idx,
  output logic [7:0] ldn,
  output logic       exit_req,
  output logic [7:0] rdata
);
  logic [7:0] idx_q;
  logic [7:0] ldn_q;

  assign exit_req = dat_we && (idx_q == IDX_EXIT) && wdata[EXIT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (exit_req)    idx_q <= '0;
      else if (idx_we) idx_q <= wdata;
      if (dat_we && (idx_q == IDX_LDN)) ldn_q <= wdata;
    end
  end

  always_comb begin
    unique case (idx_q)
      IDX_LDN:   rdata = ldn_q;
      IDX_ID_HI: rdata = CHIP_ID[15:8];
      IDX_ID_LO: rdata = CHIP_ID[7:0];
      IDX_REV:   rdata = {4'h0, CHIP_REV};
      default:   rdata = 8'h00;
    endcase
  end

  assign cur_idx = idx_q;
  assign ldn     = ldn_q;
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_LDN = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            ldn,
  input  logic [7:0]            idx,
  input  logic                  wr_en,
  input  logic [7:0]            wdata,
  output logic                  hit,
  output logic [7:0]            rdata,
  output logic [NUM_LDN-1:0]    dev_active,
  output logic [16*NUM_LDN-1:0] dev_base
);
  localparam logic [7:0] LDN_LIMIT = 8'(NUM_LDN);

  logic ldn_ok;
  logic idx_ok;
  logic [NUM_LDN-1:0] act_q;
  logic [15:0]        base_q [NUM_LDN];

  assign ldn_ok = (ldn < LDN_LIMIT);
  assign idx_ok = (idx == IDX_ACT) || (idx == IDX_BASE_HI) || (idx == IDX_BASE_LO);
  assign hit    = ldn_ok && idx_ok;

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
    logic sel;
    assign sel = wr_en && hit && (ldn == 8'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[g]  <= 1'b0;
        base_q[g] <= '0;
      end else if (sel) begin
        if (idx == IDX_ACT)     act_q[g]        <= wdata[0];
        if (idx == IDX_BASE_HI) base_q[g][15:8] <= wdata;
        if (idx == IDX_BASE_LO) base_q[g][7:0]  <= wdata;
      end
    end

    assign dev_active[g]         = act_q[g];
    assign dev_base[16*g +: 16]  = base_q[g];
  end

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NUM_LDN; k++) begin
      if (ldn == 8'(k)) begin
        if (idx == IDX_ACT)     rdata = {7'b0, act_q[k]};
        if (idx == IDX_BASE_HI) rdata = base_q[k][15:8];
        if (idx == IDX_BASE_LO) rdata = base_q[k][7:0];
      end
    end
  end
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'(16'h002F),
  parameter logic [15:0]     CHIP_ID    = 16'hA5C3,
  parameter logic [3:0]      CHIP_REV   = 4'h3,
  parameter int              NUM_LDN    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_valid,
  output logic                  host_ready,
  input  logic                  host_write,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [7:0]            host_wdata,
  output logic                  rsp_valid,
  output logic [7:0]            rsp_data,
  output logic                  cfg_open,
  output logic [7:0]            dev_num,
  output logic [7:0]            dev_index,
  output logic [7:0]            dev_wdata,
  output logic                  dev_we,
  output logic                  dev_re,
  input  logic [7:0]            dev_rdata,
  output logic [NUM_LDN-1:0]    dev_active,
  output logic [16*NUM_LDN-1:0] dev_base
);
  port_sel_e  port_sel;
  logic       accept;
  logic       open;
  logic       key_we, idx_we, dat_we, dat_re;
  logic       exit_req;
  logic [7:0] cur_idx, ldn;
  logic [7:0] glb_rdata, bank_rdata;
  logic       bank_hit;
  logic       banked_area;
  logic       to_ext;
  logic [7:0] rd_next;
  logic       rsp_valid_q;
  logic [7:0] rsp_data_q;

  always_comb begin
    if (host_addr == INDEX_PORT)     port_sel = PORT_INDEX;
    else if (host_addr == DATA_PORT) port_sel = PORT_DATA;
    else                             port_sel = PORT_NONE;
  end

  assign host_ready = !rsp_valid_q;
  assign accept     = host_valid && host_ready;

  assign key_we = accept && host_write && (port_sel == PORT_INDEX) && !open;
  assign idx_we = accept && host_write && (port_sel == PORT_INDEX) && open;
  assign dat_we = accept && host_write && (port_sel == PORT_DATA) && open;
  assign dat_re = accept && !host_write && (port_sel == PORT_DATA) && open;

  cfg_key_match u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_byte (host_wdata),
    .lock_req (exit_req),
    .open     (open)
  );

  cfg_global_regs #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_glb (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (idx_we),
    .dat_we   (dat_we),
    .wdata    (host_wdata),
    .cur_idx  (cur_idx),
    .ldn      (ldn),
    .exit_req (exit_req),
    .rdata    (glb_rdata)
  );

  assign banked_area = (cur_idx >= IDX_BANK_LO);

  cfg_dev_bank #(
    .NUM_LDN (NUM_LDN)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ldn        (ldn),
    .idx        (cur_idx),
    .wr_en      (dat_we && banked_area),
    .wdata      (host_wdata),
    .hit        (bank_hit),
    .rdata      (bank_rdata),
    .dev_active (dev_active),
    .dev_base   (dev_base)
  );

  assign to_ext = banked_area && !bank_hit;
  assign dev_we = dat_we && to_ext;
  assign dev_re = dat_re && to_ext;

  always_comb begin
    rd_next = IDLE_BYTE;
    if (open) begin
      unique case (port_sel)
        PORT_INDEX: rd_next = cur_idx;
        PORT_DATA: begin
          if (!banked_area)  rd_next = glb_rdata;
          else if (bank_hit) rd_next = bank_rdata;
          else               rd_next = dev_rdata;
        end
        default:    rd_next = IDLE_BYTE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= IDLE_BYTE;
    end else begin
      rsp_valid_q <= accept && !host_write;
      if (accept && !host_write) rsp_data_q <= rd_next;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign cfg_open  = open;
  assign dev_num   = ldn;
  assign dev_index = cur_idx;
  assign dev_wdata = host_wdata;
endmodule

// File: rtl/cfg_port_unlock_chk.sv
module cfg_port_unlock_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'(16'h002F)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_write,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              cfg_open,
  input logic [7:0]        dev_num,
  input logic [7:0]        dev_index,
  input logic              dev_we,
  input logic              dev_re
);
  AST_OPEN_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(host_valid && host_write && host_addr == INDEX_PORT && host_wdata == 8'h55)); // R1

  AST_CLOSED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (!dev_we && !dev_re)); // R3

  AST_CLOSED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(cfg_open)) |-> rsp_data == 8'hFF); // R3

  AST_CLOSED_LDN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(dev_num)); // R3

  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && host_valid && host_ready && host_write && host_addr == DATA_PORT
     && dev_index == 8'h02 && host_wdata[1]) |=> !cfg_open); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_we, dev_re})); // R9

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_write) |=> rsp_valid); // R10

  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(host_valid && host_ready && !host_write)); // R10
endmodule

bind cfg_port_unlock cfg_port_unlock_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_PORT (INDEX_PORT),
  .DATA_PORT  (DATA_PORT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_write (host_write),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .cfg_open   (cfg_open),
  .dev_num    (dev_num),
  .dev_index  (dev_index),
  .dev_we     (dev_we),
  .dev_re     (dev_re)
);

// File: tb/cfg_port_unlock_test.sv
module cfg_port_unlock_test;
  localparam int NL = 8;
  localparam logic [15:0] PI = 16'h002E;
  localparam logic [15:0] PD = 16'h002F;

  logic clk = 0;
  logic rst_n = 0;
  logic host_valid = 0, host_write = 0;
  logic [15:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ready, rsp_valid, cfg_open, dev_we, dev_re;
  logic [7:0] rsp_data, dev_num, dev_index, dev_wdata, dev_rdata;
  logic [NL-1:0] dev_active;
  logic [16*NL-1:0] dev_base;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Attached device model: answers with device number XOR index.
  assign dev_rdata = dev_num ^ dev_index;

  cfg_port_unlock uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_open(cfg_open),
    .dev_num(dev_num), .dev_index(dev_index), .dev_wdata(dev_wdata),
    .dev_we(dev_we), .dev_re(dev_re), .dev_rdata(dev_rdata),
    .dev_active(dev_active), .dev_base(dev_base)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 0; host_write = 0;
  endtask

  task automatic wr_probe(input logic [15:0] a, input logic [7:0] d, output logic we,
                          output logic [7:0] idx, output logic [7:0] num, output logic [7:0] wd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
    #1;
    we = dev_we; idx = dev_index; num = dev_num; wd = dev_wdata;
    @(negedge clk);
    host_valid = 0; host_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_write = 0; host_addr = a;
    @(negedge clk);
    host_valid = 0;
    chk(rsp_valid === 1'b1 && host_ready === 1'b0, "R10 response timing",
        {30'b0, rsp_valid, host_ready}, 32'h2);
    d = rsp_data;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(PI, idx); wr(PD, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(PI, idx); rd(PD, d);
  endtask

  task automatic key4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] e);
    wr(PI, a); wr(PI, b); wr(PI, c); wr(PI, e);
  endtask

  task automatic leave();
    reg_wr(8'h02, 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, pidx, pnum, pwd;
    logic we;
    int exp_open;

    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // Reset state
    chk(cfg_open === 1'b0, "R1 closed after reset", cfg_open, 0);
    chk(dev_num === 8'h00, "R6 device number reset", dev_num, 0);
    chk(host_ready === 1'b1 && rsp_valid === 1'b0, "R10 idle after reset",
        {host_ready, rsp_valid}, 32'h2);

    // Closed space
    rd(PD, d); chk(d == 8'hFF, "R3 closed data read", d, 8'hFF);
    rd(PI, d); chk(d == 8'hFF, "R3 closed index read", d, 8'hFF);
    wr_probe(PD, 8'h05, we, pidx, pnum, pwd);
    chk(we == 1'b0, "R3 closed write no strobe", we, 0);
    wr(16'h0080, 8'h87); wr(16'h0080, 8'h01); wr(16'h0080, 8'h55); wr(16'h0080, 8'h55);
    chk(cfg_open == 1'b0, "R10 other address ignored", cfg_open, 0);
    rd(16'h0080, d); chk(d == 8'hFF, "R10 other address read", d, 8'hFF);

    // Sweeps of key positions
    for (int pos = 1; pos < 4; pos++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b [4];
        b[0] = 8'h87; b[1] = 8'h01; b[2] = 8'h55; b[3] = 8'h55;
        exp_open = (v == int'(b[pos])) ? 1 : 0;
        b[pos] = 8'(v);
        key4(b[0], b[1], b[2], b[3]);
        chk(cfg_open == exp_open[0], "R1 key sweep", {pos[7:0], 8'(v), 15'b0, cfg_open}, exp_open);
        if (cfg_open) begin
          leave();
          chk(cfg_open == 1'b0, "R5 exit after sweep", cfg_open, 0);
        end
      end
    end

    // Restart rules
    wr(PI, 8'h87); wr(PI, 8'h01); key4(8'h87, 8'h01, 8'h55, 8'h55);
    chk(cfg_open == 1'b1, "R2 restart after partial key", cfg_open, 1);
    leave();
    wr(PI, 8'h87); key4(8'h87, 8'h01, 8'h55, 8'h55);
    chk(cfg_open == 1'b1, "R2 repeated first byte", cfg_open, 1);
    leave();
    wr(PI, 8'h87); wr(PI, 8'h01); wr(PI, 8'h55); key4(8'h87, 8'h01, 8'h55, 8'h55);
    chk(cfg_open == 1'b1, "R2 restart at last step", cfg_open, 1);
    leave();
    wr(PI, 8'h87); key4(8'h33, 8'h01, 8'h55, 8'h55);
    chk(cfg_open == 1'b0, "R2 broken sequence stays closed", cfg_open, 0);

    // Open space
    key4(8'h87, 8'h01, 8'h55, 8'h55);
    wr(PI, 8'h22); rd(PI, d); chk(d == 8'h22, "R4 index readback", d, 8'h22);
    rd(PD, d); chk(d == 8'h03, "R7 revision", d, 8'h03);
    reg_rd(8'h20, d); chk(d == 8'hA5, "R7 id high", d, 8'hA5);
    reg_rd(8'h21, d); chk(d == 8'hC3, "R7 id low", d, 8'hC3);
    reg_wr(8'h10, 8'h5A); rd(PD, d); chk(d == 8'h00, "R11 unused global", d, 0);
    reg_rd(8'h02, d); chk(d == 8'h00, "R5 exit register reads zero", d, 0);
    reg_wr(8'h07, 8'h05); rd(PD, d); chk(d == 8'h05, "R6 device number readback", d, 5);
    chk(dev_num == 8'h05, "R6 device number pin", dev_num, 5);

    // Per-device banks
    for (int k = 0; k < NL; k++) begin
      reg_wr(8'h07, 8'(k));
      reg_wr(8'h30, 8'hF0 | 8'(k % 2));
      reg_wr(8'h60, 8'h10 + 8'(k));
      reg_wr(8'h61, 8'h30 + 8'(3 * k));
    end
    for (int k = 0; k < NL; k++) begin
      reg_wr(8'h07, 8'(k));
      reg_rd(8'h30, d); chk(d == 8'(k % 2), "R8 activate readback", d, k % 2);
      reg_rd(8'h60, d); chk(d == 8'h10 + 8'(k), "R8 base high", d, 8'h10 + 8'(k));
      reg_rd(8'h61, d); chk(d == 8'h30 + 8'(3 * k), "R8 base low", d, 8'h30 + 8'(3 * k));
      chk(dev_active[k] == 1'(k % 2), "R8 activate pin", dev_active[k], k % 2);
      chk(dev_base[16*k +: 16] == {8'h10 + 8'(k), 8'h30 + 8'(3 * k)}, "R8 base pin",
          dev_base[16*k +: 16], {8'h10 + 8'(k), 8'h30 + 8'(3 * k)});
    end

    // Forwarding to the device bus
    reg_wr(8'h07, 8'h02);
    wr(PI, 8'h45);
    wr_probe(PD, 8'h9A, we, pidx, pnum, pwd);
    chk(we && pidx == 8'h45 && pnum == 8'h02 && pwd == 8'h9A, "R9 forwarded write",
        {7'b0, we, pidx, pnum, pwd}, {8'h01, 8'h45, 8'h02, 8'h9A});
    rd(PD, d); chk(d == 8'h47, "R9 forwarded read", d, 8'h47);
    reg_wr(8'h07, 8'h09);
    wr(PI, 8'h30);
    wr_probe(PD, 8'h01, we, pidx, pnum, pwd);
    chk(we == 1'b1, "R9 out-of-range device forwarded", we, 1);
    rd(PD, d); chk(d == 8'h39, "R9 out-of-range device read", d, 8'h39);
    chk(dev_active == 8'hAA, "R8 banks untouched by forward", dev_active, 8'hAA);

    // Exit rules
    reg_wr(8'h02, 8'hFD);
    chk(cfg_open == 1'b1, "R5 exit needs bit 1", cfg_open, 1);
    reg_wr(8'h02, 8'h02);
    chk(cfg_open == 1'b0, "R5 exit closes", cfg_open, 0);
    rd(PD, d); chk(d == 8'hFF, "R3 id probe when closed", d, 8'hFF);
    wr(PD, 8'h00);
    chk(dev_num == 8'h09, "R3 closed write ignored", dev_num, 8'h09);

    // Reset while open
    key4(8'h87, 8'h01, 8'h55, 8'h55);
    reg_wr(8'h07, 8'h03);
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_open == 1'b0 && dev_num == 8'h00, "R6 reset while open", {cfg_open, dev_num}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule